// File: doc/BRIEF.md
# Serial Flash Sector-Erase Sequencer

This block sits on the host side of a single-chip-select serial NOR flash bus. It erases one 4 KiB sector for each request. A one-cycle `start` pulse carries a 24-bit byte address and a bus-width selection. The block then runs three kinds of bus frames on its own. The first frame sets the device's write-enable latch. The second frame sends the sector-erase opcode followed by the address. The sequencer then repeats a status-read frame until the device's write-in-progress flag reads zero. At that point it pulses `done`. If the flag is still set after a programmable number of status reads, it pulses `error` instead.

Both command-phase widths are supported. In single-line mode, each bit takes one serial clock on `dq_out[0]`. In four-line mode, each nibble takes one serial clock on `dq_out[3:0]`, high nibble first. The serial clock runs at half the system clock. Outputs change while `sclk` is low, and the device samples them on the rising edge. Chip select is always released right after the rising edge of the last beat, so every frame ends on a whole byte. Between frames, chip select stays high for a parameterised minimum number of cycles. The device treats any address inside a sector as that sector, so the address is passed through as given.

Top module: `sfe_erase_seq`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, `dq_oe` is 0, and `busy`, `done` and `error` are 0.
- R2: The first frame after an accepted `start` carries only the write-enable opcode 0x06, sent MSB first. It is 8 serial clocks long in single-line mode and 2 in four-line mode.
- R3: The second frame carries opcode 0x20 followed by the address A23..A0, MSB first. It has exactly 32 rising `sclk` edges in single-line mode and exactly 8 in four-line mode. `cs_n` rises in the clock cycle right after the high phase of the last beat.
- R4: Single-line frames drive `dq_oe` = 4'b0001 and read status from `dq_in[1]`. Four-line frames drive `dq_oe` = 4'b1111 while sending and read status nibbles on `dq_in[3:0]`, high nibble first. Bits change while `sclk` is low.
- R5: `cs_n` stays high for at least GAP_CLKS cycles between any two frames. Between the write-enable frame and the erase frame, it stays high for exactly GAP_CLKS cycles.
- R6: After the erase frame, the block sends status-read frames (opcode 0x05, then 8 status bits). Each is 16 clocks in single-line mode and 4 clocks in four-line mode. It repeats them for as long as status bit 0 reads 1.
- R7: `done` is a one-cycle pulse. It is high in the clock cycle after the `cs_n` rise that ends the first status read with bit 0 equal to 0. `busy` is low in that same cycle, and `done` and `error` are never high together.
- R8: Let `poll_limit` be N ≥ 1. If N status reads in a row all return bit 0 equal to 1, `error` pulses once and no further frame is sent. A clear flag on read N still gives `done`.
- R9: A `start` pulse while `busy` is high is ignored. It starts no frame and does not change the address being erased.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to erase a sector |
| start_addr | input | 24 | Byte address inside the sector to erase |
| quad_mode | input | 1 | 1 selects four-line frames, 0 selects single-line frames |
| poll_limit | input | 16 | Maximum number of status reads before the request fails |
| busy | output | 1 | A request is in progress |
| done | output | 1 | Pulse: the sector erase has finished |
| error | output | 1 | Pulse: the write-in-progress flag did not clear in time |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idle low |
| dq_out | output | 4 | Serial data to the device |
| dq_oe | output | 4 | Per-line output enable for `dq_out` |
| dq_in | input | 4 | Serial data from the device |

## Verification
`start` is registered once, so `cs_n` falls and `busy` rises at the first clock edge after the cycle that sampled `start`. Each beat then lasts two clock cycles: `sclk` is low for one cycle and high for the next. `cs_n` rises at the edge that ends the high phase of the last beat. `done` or `error` appears one cycle after the final `cs_n` rise, because the status byte is judged in a separate cycle. The device model and all checks work on the falling clock edge. The model counts the rising `sclk` edges in each frame and logs the cycle of each chip-select rise. It compares the cycle in which `done` first shows against that log, expecting a difference of exactly one.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_ERASE = 8'h20;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam int         WIP_BIT  = 0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WREN, ST_ERASE, ST_POLL, ST_EVAL, ST_GAP
  } seq_state_t;

  typedef enum logic [1:0] {
    FR_WREN, FR_ERASE, FR_POLL
  } frame_kind_t;

  // serial clocks needed to move nbits over one or four lines
  function automatic int unsigned bus_beats(input int unsigned nbits, input logic quad);
    return quad ? (nbits / 4) : nbits;
  endfunction

endpackage

// File: rtl/sfe_bit_engine.sv
module sfe_bit_engine #(
  parameter int TXW = 32,
  parameter int CW  = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic           quad,
  input  logic [TXW-1:0] tx_word,
  input  logic [CW-1:0]  tx_beats,
  input  logic [CW-1:0]  rx_beats,
  input  logic [3:0]     dq_in,
  output logic           sclk,
  output logic           cs_n,
  output logic [3:0]     dq_out,
  output logic [3:0]     dq_oe,
  output logic           frame_end,
  output logic [7:0]     rx_byte
);

  logic           active, ph, quad_q;
  logic [CW-1:0]  idx, tx_n, total;
  logic [TXW-1:0] sreg;
  logic [7:0]     rx_q;

  logic last_beat, in_rx;
  assign last_beat = (idx == total - 1'b1);
  assign in_rx     = (idx >= tx_n);
  assign frame_end = active & ph & last_beat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      ph     <= 1'b0;
      quad_q <= 1'b0;
      idx    <= '0;
      tx_n   <= '0;
      total  <= '0;
      sreg   <= '0;
      rx_q   <= '0;
    end else if (go && !active) begin
      active <= 1'b1;
      ph     <= 1'b0;
      quad_q <= quad;
      idx    <= '0;
      tx_n   <= tx_beats;
      total  <= tx_beats + rx_beats;
      sreg   <= tx_word;
    end else if (active) begin
      if (!ph) begin
        ph <= 1'b1;
      end else begin
        ph <= 1'b0;
        if (in_rx) rx_q <= quad_q ? {rx_q[3:0], dq_in} : {rx_q[6:0], dq_in[1]};
        sreg <= quad_q ? (sreg << 4) : (sreg << 1);
        if (last_beat) active <= 1'b0;
        else           idx    <= idx + 1'b1;
      end
    end
  end

  assign sclk    = ph;
  assign cs_n    = ~active;
  assign rx_byte = rx_q;
  assign dq_out  = quad_q ? sreg[TXW-1 -: 4] : {3'b000, sreg[TXW-1]};

  always_comb begin
    if (!active)     dq_oe = 4'b0000;
    else if (quad_q) dq_oe = in_rx ? 4'b0000 : 4'b1111;
    else             dq_oe = 4'b0001;
  end

  // frame may only close right after a completed high phase
  assert_cs_rise_on_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> $past(sclk));

  assert_lines_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (dq_oe == 4'b0000 && !sclk));

endmodule

// File: rtl/sfe_gap_timer.sv
module sfe_gap_timer #(
  parameter int GAP_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);

  localparam int GW = $clog2(GAP_CLKS + 1);

  logic [GW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  assign expire = run && (cnt == GW'(GAP_CLKS - 1));

endmodule

// File: rtl/sfe_poll_guard.sv
module sfe_poll_guard #(
  parameter int LIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  input  logic [LIM_W-1:0] limit,
  output logic             expired
);

  logic [LIM_W-1:0] cnt;
  logic [LIM_W:0]   reads_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (tick)  cnt <= cnt + 1'b1;
  end

  // the read being judged is number cnt+1
  assign reads_now = {1'b0, cnt} + 1'b1;
  assign expired   = (reads_now >= {1'b0, limit});

endmodule

// File: rtl/sfe_erase_seq.sv
module sfe_erase_seq
  import sfe_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int GAP_CLKS = 4,
  parameter int LIM_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              quad_mode,
  input  logic [LIM_W-1:0]  poll_limit,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              cs_n,
  output logic              sclk,
  output logic [3:0]        dq_out,
  output logic [3:0]        dq_oe,
  input  logic [3:0]        dq_in
);

  localparam int TXW = 8 + ADDR_W;
  localparam int CW  = $clog2(TXW + 1);
  localparam int HRW = $clog2(GAP_CLKS + 1);

  seq_state_t        st;
  frame_kind_t       nxt_kind, go_kind;
  logic [ADDR_W-1:0] addr_q;
  logic              quad_q, quad_sel;
  logic              go, gap_exp, frame_end, last_read;
  logic [7:0]        status;
  logic [TXW-1:0]    tx_word;
  logic [CW-1:0]     tx_b, rx_b;

  // named internal events
  logic accept, wip_seen, erase_ok, timed_out;
  assign accept    = (st == ST_IDLE) && start;
  assign wip_seen  = (st == ST_EVAL) && status[WIP_BIT];
  assign erase_ok  = (st == ST_EVAL) && !status[WIP_BIT];
  assign timed_out = wip_seen && last_read;
  assign quad_sel  = (st == ST_IDLE) ? quad_mode : quad_q;

  always_comb begin
    go      = 1'b0;
    go_kind = nxt_kind;
    if (accept) begin
      go      = 1'b1;
      go_kind = FR_WREN;
    end else if (st == ST_GAP && gap_exp) begin
      go = 1'b1;
    end
  end

  always_comb begin
    case (go_kind)
      FR_WREN: begin
        tx_word = {OP_WREN, {ADDR_W{1'b0}}};
        tx_b    = CW'(bus_beats(8, quad_sel));
        rx_b    = '0;
      end
      FR_ERASE: begin
        tx_word = {OP_ERASE, addr_q};
        tx_b    = CW'(bus_beats(TXW, quad_sel));
        rx_b    = '0;
      end
      default: begin
        tx_word = {OP_RDSR, {ADDR_W{1'b0}}};
        tx_b    = CW'(bus_beats(8, quad_sel));
        rx_b    = CW'(bus_beats(8, quad_sel));
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      nxt_kind <= FR_WREN;
      addr_q   <= '0;
      quad_q   <= 1'b0;
      done     <= 1'b0;
      error    <= 1'b0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      case (st)
        ST_IDLE: if (accept) begin
          addr_q <= start_addr;
          quad_q <= quad_mode;
          st     <= ST_WREN;
        end
        ST_WREN: if (frame_end) begin
          st       <= ST_GAP;
          nxt_kind <= FR_ERASE;
        end
        ST_ERASE: if (frame_end) begin
          st       <= ST_GAP;
          nxt_kind <= FR_POLL;
        end
        ST_POLL: if (frame_end) st <= ST_EVAL;
        ST_EVAL: begin
          if (erase_ok) begin
            done <= 1'b1;
            st   <= ST_IDLE;
          end else if (timed_out) begin
            error <= 1'b1;
            st    <= ST_IDLE;
          end else begin
            st <= ST_GAP;
          end
        end
        ST_GAP: if (gap_exp) st <= (nxt_kind == FR_ERASE) ? ST_ERASE : ST_POLL;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy = (st != ST_IDLE);

  sfe_bit_engine #(.TXW(TXW), .CW(CW)) u_engine (
    .clk(clk), .rst_n(rst_n), .go(go), .quad(quad_sel),
    .tx_word(tx_word), .tx_beats(tx_b), .rx_beats(rx_b), .dq_in(dq_in),
    .sclk(sclk), .cs_n(cs_n), .dq_out(dq_out), .dq_oe(dq_oe),
    .frame_end(frame_end), .rx_byte(status)
  );

  sfe_gap_timer #(.GAP_CLKS(GAP_CLKS)) u_gap (
    .clk(clk), .rst_n(rst_n), .run(st == ST_GAP), .expire(gap_exp)
  );

  sfe_poll_guard #(.LIM_W(LIM_W)) u_guard (
    .clk(clk), .rst_n(rst_n), .clear(accept), .tick(wip_seen),
    .limit(poll_limit), .expired(last_read)
  );

  // ---- checker state for the assertions ----
  logic [HRW-1:0]   hi_run;
  logic [LIM_W-1:0] polls_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            hi_run <= '0;
    else if (!cs_n)                        hi_run <= '0;
    else if (hi_run < HRW'(GAP_CLKS))      hi_run <= hi_run + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            polls_seen <= '0;
    else if (accept)                       polls_seen <= '0;
    else if (frame_end && st == ST_POLL)   polls_seen <= polls_seen + 1'b1;
  end

  assert_gap_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) && st != ST_WREN) |-> (hi_run >= HRW'(GAP_CLKS)));

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && cs_n && $past(cs_n)));

  assert_done_error_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  assert_timeout_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (error && poll_limit != '0) |-> (polls_seen == poll_limit));

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(addr_q));

endmodule

// File: tb/sim_sfe_erase_seq.sv
module sim_sfe_erase_seq;

  localparam int GAP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] start_addr = '0;
  logic        quad_mode = 1'b0;
  logic [15:0] poll_limit = 16'd8;
  logic        busy, done, error, cs_n, sclk;
  logic [3:0]  dq_out, dq_oe;
  logic [3:0]  dq_in = 4'b0000;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  sfe_erase_seq #(.ADDR_W(24), .GAP_CLKS(GAP), .LIM_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .quad_mode(quad_mode), .poll_limit(poll_limit), .busy(busy), .done(done),
    .error(error), .cs_n(cs_n), .sclk(sclk), .dq_out(dq_out), .dq_oe(dq_oe),
    .dq_in(dq_in)
  );

  // ---------------- device model, evaluated on falling clk ----------------
  logic        quad_tb = 1'b0;
  logic        prev_sclk = 1'b0, prev_cs = 1'b1, stat_live = 1'b0;
  logic [31:0] cap = '0;
  logic [7:0]  stat_sh = '0;
  logic [3:0]  oe_first = '0;
  int cyc = 0, bitcnt = 0, edges = 0, busy_left = 0, hi = 0;
  int nfr = 0, min_gap = 1000, last_rise = 0, done_cyc = 0, done_cnt = 0, err_cnt = 0;
  logic [31:0] fr_cap [0:63];
  logic [7:0]  fr_op  [0:63];
  logic [3:0]  fr_oe  [0:63];
  int          fr_edges [0:63];

  always @(negedge clk) begin
    if (rst_n) begin
      cyc = cyc + 1;
      if (cs_n && !prev_cs) begin
        if (nfr < 64) begin
          fr_cap[nfr]   = cap;
          fr_op[nfr]    = 8'(cap >> (bitcnt - 8));
          fr_edges[nfr] = edges;
          fr_oe[nfr]    = oe_first;
        end
        nfr = nfr + 1;
        last_rise = cyc;
        hi = 0;
      end
      if (!cs_n && prev_cs) begin
        if (nfr > 0 && hi < min_gap) min_gap = hi;
        cap = '0; bitcnt = 0; edges = 0; stat_live = 1'b0;
      end
      if (cs_n) hi = hi + 1;
      if (!cs_n && sclk && !prev_sclk) begin
        edges = edges + 1;
        if (edges == 1) oe_first = dq_oe;
        if (bitcnt < 32) begin
          cap    = quad_tb ? {cap[27:0], dq_out} : {cap[30:0], dq_out[0]};
          bitcnt = bitcnt + (quad_tb ? 4 : 1);
        end
        if (edges == (quad_tb ? 2 : 8) && cap[7:0] == 8'h05) begin
          stat_sh   = {7'b0, (busy_left > 0)};
          if (busy_left > 0) busy_left = busy_left - 1;
          stat_live = 1'b1;
        end
      end
      if (!cs_n && !sclk && prev_sclk && stat_live) begin
        if (quad_tb) begin
          dq_in   = stat_sh[7:4];
          stat_sh = stat_sh << 4;
        end else begin
          dq_in   = {2'b00, stat_sh[7], 1'b0};
          stat_sh = stat_sh << 1;
        end
      end
      if (done)  begin done_cnt = done_cnt + 1; done_cyc = cyc; end
      if (error) err_cnt = err_cnt + 1;
    end
    prev_sclk = sclk;
    prev_cs   = cs_n;
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic launch(input logic [23:0] a, input logic q, input int nbusy, input logic [15:0] lim);
    @(negedge clk);
    nfr = 0; done_cnt = 0; err_cnt = 0; min_gap = 1000; busy_left = nbusy; quad_tb = q;
    start_addr = a; quad_mode = q; poll_limit = lim; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle;
    int n = 0;
    while (busy && n < 50000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    chk("R1", "cs_n", cs_n, 1);
    chk("R1", "sclk", sclk, 0);
    chk("R1", "dq_oe", dq_oe, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "error", error, 0);
  endtask

  task automatic t_single_line;
    logic [23:0] a = 24'h3A5F17;
    launch(a, 1'b0, 3, 16'd10);
    repeat (40) @(negedge clk);
    start_addr = 24'h111111; start = 1'b1;   // R9: must be ignored
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    chk("R6", "frame count", nfr, 6);
    chk("R2", "wren opcode", fr_op[0], 8'h06);
    chk("R2", "wren clocks", fr_edges[0], 8);
    chk("R4", "spi oe", fr_oe[0], 4'b0001);
    chk("R3", "erase word", fr_cap[1], {8'h20, a});
    chk("R3", "erase clocks", fr_edges[1], 32);
    for (int i = 2; i < 6; i++) begin
      chk("R6", "poll opcode", fr_op[i], 8'h05);
      chk("R6", "poll clocks", fr_edges[i], 16);
    end
    chk("R7", "done pulses", done_cnt, 1);
    chk("R7", "done delay", done_cyc - last_rise, 1);
    chk("R8", "no error", err_cnt, 0);
    chk("R5", "min gap", min_gap, GAP);
    chk("R7", "busy after", busy, 0);
    repeat (80) @(negedge clk);
    chk("R9", "no extra frame", nfr, 6);
  endtask

  task automatic t_four_line;
    logic [23:0] a = 24'hFFF000;
    launch(a, 1'b1, 0, 16'd4);
    wait_idle();
    chk("R6", "frame count", nfr, 3);
    chk("R2", "wren opcode", fr_op[0], 8'h06);
    chk("R2", "wren clocks", fr_edges[0], 2);
    chk("R4", "qpi oe", fr_oe[0], 4'b1111);
    chk("R3", "erase word", fr_cap[1], {8'h20, a});
    chk("R3", "erase clocks", fr_edges[1], 8);
    chk("R6", "poll clocks", fr_edges[2], 4);
    chk("R4", "qpi status done", done_cnt, 1);
    chk("R5", "min gap", min_gap, GAP);
  endtask

  task automatic t_timeout;
    launch(24'h00ABCD, 1'b0, 1000, 16'd3);
    wait_idle();
    chk("R8", "error pulses", err_cnt, 1);
    chk("R8", "no done", done_cnt, 0);
    chk("R8", "frames", nfr, 5);
    repeat (80) @(negedge clk);
    chk("R8", "no frame after error", nfr, 5);
    chk("R8", "busy after", busy, 0);
  endtask

  task automatic t_last_read_clear;
    launch(24'h000FFF, 1'b1, 2, 16'd3);
    wait_idle();
    chk("R8", "clear on last read done", done_cnt, 1);
    chk("R8", "clear on last read no error", err_cnt, 0);
    chk("R6", "frames", nfr, 5);
    chk("R3", "low address", fr_cap[1], {8'h20, 24'h000FFF});
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_single_line();
    t_four_line();
    t_timeout();
    t_last_read_clear();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule